// File: doc/BRIEF.md
# Event Counter Bank with Shared or Per-Event Counting

This block accumulates processor event pulses into 32-bit counters that software reaches through a plain CSR read/write port. Three kinds of register are visible. A two-bit mode register holds a global run switch and a saturate/wrap select. An enable mask has one bit per event class. A window of 32 counter addresses holds the counts. Event generation is outside the block: each `evt_i` bit is a level sampled on every clock edge, and each sampled cycle counts as one occurrence.

A parameter picks one of two builds. The per-event build gives every event line its own counter. Writing the last counter address loads every counter at once. The shared build keeps one counter, to save area. It adds one whenever at least one enabled event is high, however many are high, and every counter address maps to that one register.

The CSR port has no valid/ready handshake. A write takes effect on the clock edge where `csr_we_i` is high, and read data follows the address combinationally. No data stream crosses the block's edge, so there is no back-pressure to manage.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, the mode register at 0x7A1 reads 0x3, the mask at 0x7A0 reads 0, and every counter reads 0.
- R2: The mode register at 0x7A1 is written and read back in bits [1:0]. Bit 1 is the global run switch and bit 0 selects saturation when 1. When bit 1 is 0, no counter changes.
- R3: The enable mask at 0x7A0 uses its low NUM_EVT bits. Bit n set lets event n count.
- R4: In the per-event build, counter n at address 0x780+n increases by exactly one on each edge where `evt_i[n]` is high, its mask bit is set and the run switch is on.
- R5: An event whose mask bit is 0 leaves every counter it feeds unchanged.
- R6: In the shared build, the single counter increases by exactly one on each edge where at least one enabled event is high, even when several are high together.
- R7: In the shared build, every address from 0x780 to 0x79F reads and writes the same register.
- R8: In the per-event build, a write to 0x79F loads the written value into every counter.
- R9: In saturating mode, a counter holding 0xFFFF_FFFF keeps that value when it receives further events.
- R10: In wrap mode, a counter holding 0xFFFF_FFFF goes to 0 on its next event.
- R11: A CSR write to a counter on the same edge as an increment loads the written value, and the increment is lost.
- R12: Event pulses on separate cycles each count once, so an access split into two halves counts two.
- R13: Read data is combinational from `csr_addr_i`. In the per-event build, counter addresses with no counter behind them (including 0x79F) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event levels, one bit per event class |
| csr_we_i | input | 1 | Write strobe for the CSR port |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for `csr_addr_i` |

## Verification
The cases hardest to reach from the ports are the counter's value limits. Counting up to 0xFFFF_FFFF one event at a time would take far too many cycles. So the stimulus writes 0xFFFF_FFFE into a counter, then drives three event cycles, once in saturating mode and once in wrap mode. The collision between a software write and an increment needs an event level and a write strobe on the same edge. A dedicated task drives both together. Both builds receive identical stimulus, so the OR-and-count-once behaviour of the shared build is checked against the separate counts of the per-event build.

// File: rtl/perfcnt_pkg.sv
package perfcnt_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned AW     = 12;
  localparam int unsigned IDX_W  = 5;
  localparam logic [AW-1:0] ADDR_MODE = 12'h7A1;
  localparam logic [AW-1:0] ADDR_MASK = 12'h7A0;
  localparam logic [AW-1:0] ADDR_CNT0 = 12'h780;
  localparam logic [IDX_W-1:0] IDX_ALL = 5'd31;

  typedef struct packed {
    logic run;
    logic sat;
  } mode_t;
endpackage

// File: rtl/pc_csr_decode.sv
module pc_csr_decode
  import perfcnt_pkg::*;
(
  input  logic [AW-1:0]    addr_i,
  output logic             sel_mode_o,
  output logic             sel_mask_o,
  output logic             sel_cnt_o,
  output logic             sel_all_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    sel_mode_o = (addr_i == ADDR_MODE);
    sel_mask_o = (addr_i == ADDR_MASK);
    sel_cnt_o  = (addr_i[AW-1:IDX_W] == ADDR_CNT0[AW-1:IDX_W]);
    idx_o      = addr_i[IDX_W-1:0];
    sel_all_o  = sel_cnt_o && (idx_o == IDX_ALL);
  end
endmodule

// File: rtl/pc_counter_cell.sv
module pc_counter_cell #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic         sat_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic         at_top;

  assign at_top = &cnt_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= wdata_i;
    else if (inc_i && !(sat_i && at_top)) cnt_q <= cnt_q + 1'b1;
  end

  // R11
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(wdata_i));
  // R9
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && sat_i && cnt_q == {W{1'b1}}) |=> cnt_q == {W{1'b1}});
  // R10
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc_i && !sat_i && cnt_q == {W{1'b1}}) |=> cnt_q == '0);
  // R4
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc_i && cnt_q != {W{1'b1}}) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import perfcnt_pkg::*;
#(
  parameter int unsigned NUM_EVT = 16,
  parameter bit          SHARED  = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               csr_we_i,
  input  logic [AW-1:0]      csr_addr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o
);
  localparam int unsigned NUM_CNT = SHARED ? 1 : NUM_EVT;

  logic             sel_mode, sel_mask, sel_cnt, sel_all;
  logic [IDX_W-1:0] idx;
  mode_t            mode_q;
  logic [NUM_EVT-1:0] mask_q, live_evt;
  logic [XLEN-1:0]  cnt [NUM_CNT];

  pc_csr_decode u_dec (
    .addr_i     (csr_addr_i),
    .sel_mode_o (sel_mode),
    .sel_mask_o (sel_mask),
    .sel_cnt_o  (sel_cnt),
    .sel_all_o  (sel_all),
    .idx_o      (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '{run: 1'b1, sat: 1'b1};
      mask_q <= '0;
    end else if (csr_we_i) begin
      if (sel_mode) mode_q <= mode_t'(csr_wdata_i[1:0]);
      if (sel_mask) mask_q <= csr_wdata_i[NUM_EVT-1:0];
    end
  end

  assign live_evt = mode_q.run ? (evt_i & mask_q) : '0;

  generate
    if (SHARED) begin : g_shared
      pc_counter_cell #(.W(XLEN)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (|live_evt),
        .load_i  (csr_we_i && sel_cnt),
        .sat_i   (mode_q.sat),
        .wdata_i (csr_wdata_i),
        .cnt_o   (cnt[0])
      );
    end else begin : g_per_evt
      for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        pc_counter_cell #(.W(XLEN)) u_cnt (
          .clk_i   (clk_i),
          .rst_ni  (rst_ni),
          .inc_i   (live_evt[g]),
          .load_i  (csr_we_i && sel_cnt && (sel_all || idx == IDX_W'(g))),
          .sat_i   (mode_q.sat),
          .wdata_i (csr_wdata_i),
          .cnt_o   (cnt[g])
        );
      end
    end
  endgenerate

  always_comb begin
    csr_rdata_o = '0;
    if (sel_mode) begin
      csr_rdata_o[1:0] = mode_q;
    end else if (sel_mask) begin
      csr_rdata_o[NUM_EVT-1:0] = mask_q;
    end else if (sel_cnt) begin
      if (SHARED) begin
        csr_rdata_o = cnt[0];
      end else begin
        for (int k = 0; k < NUM_CNT; k++)
          if (idx == IDX_W'(k)) csr_rdata_o = cnt[k];
      end
    end
  end

  // R2
  mode_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && sel_mode) |=> mode_q == $past(csr_wdata_i[1:0]));
  // R3
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && sel_mask) |=> mask_q == $past(csr_wdata_i[NUM_EVT-1:0]));
  // R2
  run_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.run |-> live_evt == '0);
endmodule

// File: tb/test_perf_counter_unit.sv
module test_perf_counter_unit;
  localparam int NE = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic          we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rd_p, rd_s;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp_p;
    logic [31:0] exp_s;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  perf_counter_unit #(.NUM_EVT(NE), .SHARED(1'b0)) i_perf_counter_unit (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .csr_we_i(we),
    .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rd_p));

  perf_counter_unit #(.NUM_EVT(NE), .SHARED(1'b1)) i_perf_counter_unit_shared (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .csr_we_i(we),
    .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rd_s));

  // monitor: pops one expectation per cycle and compares both builds
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_chk += 2;
        if (rd_p !== it.exp_p) begin
          n_fail++;
          $display("FAIL %s per-event addr=%h actual=%h expected=%h", it.tag, addr, rd_p, it.exp_p);
        end
        if (rd_s !== it.exp_s) begin
          n_fail++;
          $display("FAIL %s shared addr=%h actual=%h expected=%h", it.tag, addr, rd_s, it.exp_s);
        end
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] ep, input logic [31:0] es, input string tag);
    item_t it;
    @(posedge clk); #0.5;
    we = 1'b0; addr = a;
    it.exp_p = ep; it.exp_s = es; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #0.5;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #0.5;
    we = 1'b0;
  endtask

  task automatic pulse(input logic [NE-1:0] e, input int n);
    @(posedge clk); #0.5;
    evt = e;
    for (int i = 0; i < n; i++) @(posedge clk);
    #0.5 evt = '0;
  endtask

  task automatic wr_with_evt(input logic [11:0] a, input logic [31:0] d, input logic [NE-1:0] e);
    @(posedge clk); #0.5;
    we = 1'b1; addr = a; wdata = d; evt = e;
    @(posedge clk); #0.5;
    we = 1'b0; evt = '0;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    // R1 reset values
    rd(12'h7A1, 32'h3, 32'h3, "R1 mode");
    rd(12'h7A0, 32'h0, 32'h0, "R1 mask");
    rd(12'h780, 32'h0, 32'h0, "R1 cnt");
    // R5 masked event leaves counters alone
    pulse(16'h0001, 5);
    rd(12'h780, 32'h0, 32'h0, "R5 masked");
    // R3 mask write
    wr(12'h7A0, 32'h0003);
    rd(12'h7A0, 32'h3, 32'h3, "R3 mask rb");
    // R4 / R6 simultaneous events
    pulse(16'h0003, 4);
    rd(12'h780, 32'd4, 32'd4, "R4 cnt0");
    rd(12'h781, 32'd4, 32'd4, "R6 cnt1");
    rd(12'h782, 32'd0, 32'd4, "R7 alias");
    pulse(16'h0002, 2);
    rd(12'h781, 32'd6, 32'd6, "R4 cnt1");
    rd(12'h780, 32'd4, 32'd6, "R6 single");
    // R5 event with mask bit clear
    pulse(16'h0004, 3);
    rd(12'h782, 32'd0, 32'd6, "R5 bit2");
    // R12 two separate pulses count twice
    pulse(16'h0001, 1);
    @(posedge clk);
    pulse(16'h0001, 1);
    rd(12'h780, 32'd6, 32'd8, "R12 halves");
    // R2 global switch off, saturate on
    wr(12'h7A1, 32'h1);
    pulse(16'h0003, 3);
    rd(12'h780, 32'd6, 32'd8, "R2 stopped");
    rd(12'h7A1, 32'h1, 32'h1, "R2 mode rb");
    // R9 saturation
    wr(12'h7A1, 32'h3);
    wr(12'h780, 32'hFFFF_FFFE);
    pulse(16'h0001, 3);
    rd(12'h780, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 sat");
    // R10 wrap
    wr(12'h7A1, 32'h2);
    wr(12'h780, 32'hFFFF_FFFE);
    pulse(16'h0001, 3);
    rd(12'h780, 32'h1, 32'h1, "R10 wrap");
    // R8 broadcast write
    wr(12'h79F, 32'h100);
    rd(12'h780, 32'h100, 32'h100, "R8 cnt0");
    rd(12'h781, 32'h100, 32'h100, "R8 cnt1");
    rd(12'h78F, 32'h100, 32'h100, "R8 cnt15");
    rd(12'h79F, 32'h0, 32'h100, "R13 idx31");
    // R11 write beats increment
    wr_with_evt(12'h780, 32'h55, 16'h0001);
    rd(12'h780, 32'h55, 32'h55, "R11 cnt0");
    rd(12'h781, 32'h100, 32'h55, "R11 cnt1");
    // R7 shared aliasing on write
    wr(12'h785, 32'd7);
    rd(12'h780, 32'h55, 32'd7, "R7 wr alias");
    rd(12'h785, 32'd7, 32'd7, "R7 rd");
    // R13 unmapped address
    rd(12'h123, 32'h0, 32'h0, "R13 unmapped");
    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule